// File: doc/BRIEF.md
# Vertex Fetch Address Generator

This block turns a draw command into a stream of memory read requests for vertex data. Software programs a small register window through a one-cycle write port: a base address, a set of per-loader descriptors (offset, bytes per vertex, component count), an index array descriptor and a vertex count. A write to one of two trigger words starts a draw, either plain or indexed. For every vertex the block emits one request per active loader, each carrying a byte address and a byte length. In an indexed draw it first requests the vertex's index from memory, waits for that index on a return channel, and then uses it as the vertex number.

Requests leave through a valid/ready channel. Once `req_valid` is high, the request fields hold steady until the consumer takes them with `req_ready`. The consumer may hold `req_ready` low for any number of cycles. Index data comes back through a second valid/ready channel on which the block is the receiver. `busy` and `done` are plain status pins. The block does not capture attribute data, unpack it, convert formats or shade.

Top module: `vtx_fetch_agen`

## Requirements
- R1: After reset, `busy`, `done`, `req_valid` and `idx_rready` are low, and no request appears until a trigger word is written.
- R2: Any write to word 0x22E starts a plain draw. Vertex i, for i from 0 to count-1, uses vertex number i. The count is bits 31:0 of word 0x228 and is captured at the trigger.
- R3: An attribute request for loader L and vertex number v has `req_addr` = base*8 + offset_L + v*bytes_L (modulo 2^32), `req_len` = bytes_L, `req_kind` = 0 and `req_loader` = L. The fields are laid out as follows. The base is bits 28:0 of word 0x200. Loader L owns words 0x203+3L to 0x205+3L. Its offset is all 32 bits of the first of these words. In the third word, bytes_L sits in bits 23:16 and the component count in bits 31:28.
- R4: Within a vertex, requests go out in ascending loader order, and a loader whose component count is zero is skipped. Vertices are handled in ascending order.
- R5: Any write to word 0x22F starts an indexed draw. The index width w is 1 byte when bit 31 of word 0x227 is 0 and 2 bytes when it is 1. Before its attribute requests, vertex i issues an index request with `req_kind` = 1, `req_loader` = 0, `req_len` = w and `req_addr` = base*8 + idxoff + i*w, where idxoff is bits 30:0 of word 0x227. The block then raises `idx_rready` and takes the vertex number from `idx_rdata[7:0]` (w=1) or `idx_rdata[15:0]` (w=2, little-endian: the lower-addressed byte is in bits 7:0).
- R6: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and every request field stays stable. A request transfers on a clock edge where both are high. `req_valid` is never high while `idx_rready` is high.
- R7: `busy` rises in the cycle after an accepted trigger. It falls right after the edge that accepts the last request. `done` is high for exactly one cycle, which is the first cycle with `busy` low.
- R8: A trigger write made while `busy` is high is ignored: no further requests and no second `done` follow the current draw.
- R9: A trigger with a count of 0, or with no loader whose component count is nonzero, issues no request (index requests included), leaves `busy` low and pulses `done` in the cycle after the trigger.
- R10: Writes to words 0x201, 0x202 and 0x204+3L, and to unmapped words, do not change any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted by consumer |
| req_addr | output | 32 | Request byte address |
| req_len | output | 8 | Request byte length |
| req_kind | output | 1 | 0 = attribute data, 1 = vertex index |
| req_loader | output | 4 | Loader number of an attribute request |
| idx_rvalid | input | 1 | Index return valid |
| idx_rready | output | 1 | Block waits for an index |
| idx_rdata | input | 16 | Returned index bytes, little-endian |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle draw completion pulse |

## Verification
The hardest case to reach from the ports is a trigger write that lands while an indexed draw is stalled, either with a request held back by `req_ready` or with the block waiting on an index that has not returned. In that case the block must neither restart nor add a vertex. The stimulus injects a trigger write three cycles into long draws, while `req_ready` and `idx_rvalid` are driven with random duty cycles so that stalls pile up around it. Directed draws cover the degenerate cases (a count of zero, every loader inactive) and writes to words the block must ignore.

// File: rtl/vfa_pkg.sv
package vfa_pkg;
  localparam int CFG_AW = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int IDX_W  = 16;

  localparam logic [CFG_AW-1:0] REG_BASE     = 10'h200;
  localparam logic [CFG_AW-1:0] REG_LDR0     = 10'h203;
  localparam int                LDR_STRIDE   = 3;
  localparam logic [CFG_AW-1:0] REG_IDXDESC  = 10'h227;
  localparam logic [CFG_AW-1:0] REG_VCOUNT   = 10'h228;
  localparam logic [CFG_AW-1:0] REG_GO_PLAIN = 10'h22E;
  localparam logic [CFG_AW-1:0] REG_GO_INDEX = 10'h22F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IDX_REQ,
    ST_IDX_WAIT,
    ST_ATTR,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/vfa_regfile.sv
module vfa_regfile
  import vfa_pkg::*;
#(
  parameter int NUM_LDR = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [CFG_AW-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [28:0]                   base_units,
  output logic [NUM_LDR-1:0][31:0]      ldr_off,
  output logic [NUM_LDR-1:0][LEN_W-1:0] ldr_bytes,
  output logic [NUM_LDR-1:0]            ldr_active,
  output logic [30:0]                   idx_off,
  output logic                          idx_wide,
  output logic [31:0]                   vcount,
  output logic                          go_plain,
  output logic                          go_index
);
  // Shared registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_units <= '0;
      idx_off    <= '0;
      idx_wide   <= 1'b0;
      vcount     <= '0;
    end else if (we) begin
      if (addr == REG_BASE)    base_units <= wdata[28:0];
      if (addr == REG_IDXDESC) begin
        idx_off  <= wdata[30:0];
        idx_wide <= wdata[31];
      end
      if (addr == REG_VCOUNT)  vcount <= wdata;
    end
  end

  // One descriptor per loader
  for (genvar g = 0; g < NUM_LDR; g++) begin : g_ldr
    localparam logic [CFG_AW-1:0] W_OFF  = CFG_AW'(int'(REG_LDR0) + LDR_STRIDE * g);
    localparam logic [CFG_AW-1:0] W_SIZE = CFG_AW'(int'(REG_LDR0) + LDR_STRIDE * g + 2);
    logic [3:0] comp_cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ldr_off[g]   <= '0;
        ldr_bytes[g] <= '0;
        comp_cnt     <= '0;
      end else if (we) begin
        if (addr == W_OFF)  ldr_off[g] <= wdata;
        if (addr == W_SIZE) begin
          ldr_bytes[g] <= wdata[23:16];
          comp_cnt     <= wdata[31:28];
        end
      end
    end

    assign ldr_active[g] = |comp_cnt;
  end

  assign go_plain = we && (addr == REG_GO_PLAIN);
  assign go_index = we && (addr == REG_GO_INDEX);
endmodule

// File: rtl/vfa_ldr_scan.sv
module vfa_ldr_scan #(
  parameter int NUM_LDR = 12,
  localparam int LW = (NUM_LDR > 1) ? $clog2(NUM_LDR) : 1
) (
  input  logic [NUM_LDR-1:0] mask,
  input  logic [LW-1:0]      cur,
  output logic [LW-1:0]      first_ldr,
  output logic               first_ok,
  output logic [LW-1:0]      next_ldr,
  output logic               next_ok
);
  // Lowest set loader overall
  always_comb begin
    first_ok  = 1'b0;
    first_ldr = '0;
    for (int k = NUM_LDR - 1; k >= 0; k--) begin
      if (mask[k]) begin
        first_ok  = 1'b1;
        first_ldr = LW'(k);
      end
    end
  end

  // Lowest set loader strictly above cur
  always_comb begin
    next_ok  = 1'b0;
    next_ldr = '0;
    for (int k = NUM_LDR - 1; k >= 0; k--) begin
      if (mask[k] && (k > int'(cur))) begin
        next_ok  = 1'b1;
        next_ldr = LW'(k);
      end
    end
  end
endmodule

// File: rtl/vfa_addr_calc.sv
module vfa_addr_calc
  import vfa_pkg::*;
(
  input  logic [28:0]       base_units,
  input  logic [31:0]       sel_off,
  input  logic [LEN_W-1:0]  sel_bytes,
  input  logic [ADDR_W-1:0] vtx_idx,
  input  logic [ADDR_W-1:0] vtx_num,
  input  logic [30:0]       idx_off,
  input  logic              idx_wide,
  input  logic              is_idx,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len
);
  logic [ADDR_W-1:0] base_b;
  logic [ADDR_W-1:0] attr_addr;
  logic [ADDR_W-1:0] idx_addr;
  logic [ADDR_W-1:0] idx_step;

  assign base_b    = {base_units, 3'b000};
  assign attr_addr = base_b + sel_off + (vtx_idx * ADDR_W'(sel_bytes));
  assign idx_step  = idx_wide ? {vtx_num[ADDR_W-2:0], 1'b0} : vtx_num;
  assign idx_addr  = base_b + {1'b0, idx_off} + idx_step;

  always_comb begin
    if (is_idx) begin
      addr = idx_addr;
      len  = idx_wide ? LEN_W'(2) : LEN_W'(1);
    end else begin
      addr = attr_addr;
      len  = sel_bytes;
    end
  end
endmodule

// File: rtl/vfa_seq.sv
module vfa_seq
  import vfa_pkg::*;
#(
  parameter int NUM_LDR = 12,
  localparam int LW = (NUM_LDR > 1) ? $clog2(NUM_LDR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_plain,
  input  logic               go_index,
  input  logic [31:0]        vcount,
  input  logic [NUM_LDR-1:0] active_mask,
  input  logic               idx_wide,
  input  logic [LW-1:0]      first_ldr,
  input  logic               first_ok,
  input  logic [LW-1:0]      next_ldr,
  input  logic               next_ok,
  input  logic               req_ready,
  input  logic               idx_rvalid,
  input  logic [IDX_W-1:0]   idx_rdata,
  output logic [LW-1:0]      cur_ldr,
  output logic [ADDR_W-1:0]  vtx_num,
  output logic [ADDR_W-1:0]  vtx_idx,
  output logic               req_valid,
  output logic               req_is_idx,
  output logic               idx_rready,
  output logic               busy,
  output logic               done
);
  seq_state_e        state;
  logic [31:0]       cnt_q;
  logic              indexed_q;
  logic              last_vtx;

  assign last_vtx = (vtx_num == (cnt_q - 32'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt_q     <= '0;
      indexed_q <= 1'b0;
      cur_ldr   <= '0;
      vtx_num   <= '0;
      vtx_idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go_plain || go_index) begin
            cnt_q     <= vcount;
            indexed_q <= go_index;
            vtx_num   <= '0;
            vtx_idx   <= '0;
            cur_ldr   <= first_ldr;
            if ((vcount == 32'd0) || !first_ok) state <= ST_FIN;
            else if (go_index)                  state <= ST_IDX_REQ;
            else                                state <= ST_ATTR;
          end
        end
        ST_IDX_REQ: begin
          if (req_ready) state <= ST_IDX_WAIT;
        end
        ST_IDX_WAIT: begin
          if (idx_rvalid) begin
            vtx_idx <= idx_wide ? ADDR_W'(idx_rdata) : ADDR_W'(idx_rdata[7:0]);
            cur_ldr <= first_ldr;
            state   <= ST_ATTR;
          end
        end
        ST_ATTR: begin
          if (req_ready) begin
            if (next_ok) begin
              cur_ldr <= next_ldr;
            end else if (last_vtx) begin
              state <= ST_FIN;
            end else begin
              vtx_num <= vtx_num + 1'b1;
              cur_ldr <= first_ldr;
              if (indexed_q) begin
                state <= ST_IDX_REQ;
              end else begin
                vtx_idx <= vtx_num + 1'b1;
              end
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_valid  = (state == ST_IDX_REQ) || (state == ST_ATTR);
  assign req_is_idx = (state == ST_IDX_REQ);
  assign idx_rready = (state == ST_IDX_WAIT);
  assign busy       = (state == ST_IDX_REQ) || (state == ST_IDX_WAIT) || (state == ST_ATTR);
  assign done       = (state == ST_FIN);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_is_idx) && $stable(cur_ldr) && $stable(vtx_num) && $stable(vtx_idx)) // R6
    else $error("request changed while stalled");

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) // R7
    else $error("done longer than one cycle");

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(state) != ST_FIN) // R7
    else $error("done overlaps busy");

  AST_IDX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rready |-> !req_valid) // R6
    else $error("request while waiting for index");

  AST_LDR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_is_idx && $stable(active_mask) |-> active_mask[cur_ldr]) // R4
    else $error("request for inactive loader");

  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (go_plain || go_index) |=> (busy || done) && $stable(cnt_q)) // R8
    else $error("trigger taken while busy");
endmodule

// File: rtl/vtx_fetch_agen.sv
module vtx_fetch_agen
  import vfa_pkg::*;
#(
  parameter int NUM_LDR = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [9:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [31:0]        req_addr,
  output logic [7:0]         req_len,
  output logic               req_kind,
  output logic [3:0]         req_loader,
  input  logic               idx_rvalid,
  output logic               idx_rready,
  input  logic [15:0]        idx_rdata,
  output logic               busy,
  output logic               done
);
  localparam int LW = (NUM_LDR > 1) ? $clog2(NUM_LDR) : 1;

  logic [28:0]                   base_units;
  logic [NUM_LDR-1:0][31:0]      ldr_off;
  logic [NUM_LDR-1:0][LEN_W-1:0] ldr_bytes;
  logic [NUM_LDR-1:0]            ldr_active;
  logic [30:0]                   idx_off;
  logic                          idx_wide;
  logic [31:0]                   vcount;
  logic                          go_plain;
  logic                          go_index;
  logic [LW-1:0]                 first_ldr;
  logic                          first_ok;
  logic [LW-1:0]                 next_ldr;
  logic                          next_ok;
  logic [LW-1:0]                 cur_ldr;
  logic [ADDR_W-1:0]             vtx_num;
  logic [ADDR_W-1:0]             vtx_idx;
  logic                          req_is_idx;
  logic [31:0]                   sel_off;
  logic [LEN_W-1:0]              sel_bytes;

  vfa_regfile #(.NUM_LDR(NUM_LDR)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .base_units (base_units),
    .ldr_off    (ldr_off),
    .ldr_bytes  (ldr_bytes),
    .ldr_active (ldr_active),
    .idx_off    (idx_off),
    .idx_wide   (idx_wide),
    .vcount     (vcount),
    .go_plain   (go_plain),
    .go_index   (go_index)
  );

  vfa_ldr_scan #(.NUM_LDR(NUM_LDR)) u_scan (
    .mask      (ldr_active),
    .cur       (cur_ldr),
    .first_ldr (first_ldr),
    .first_ok  (first_ok),
    .next_ldr  (next_ldr),
    .next_ok   (next_ok)
  );

  vfa_seq #(.NUM_LDR(NUM_LDR)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_plain    (go_plain),
    .go_index    (go_index),
    .vcount      (vcount),
    .active_mask (ldr_active),
    .idx_wide    (idx_wide),
    .first_ldr   (first_ldr),
    .first_ok    (first_ok),
    .next_ldr    (next_ldr),
    .next_ok     (next_ok),
    .req_ready   (req_ready),
    .idx_rvalid  (idx_rvalid),
    .idx_rdata   (idx_rdata),
    .cur_ldr     (cur_ldr),
    .vtx_num     (vtx_num),
    .vtx_idx     (vtx_idx),
    .req_valid   (req_valid),
    .req_is_idx  (req_is_idx),
    .idx_rready  (idx_rready),
    .busy        (busy),
    .done        (done)
  );

  assign sel_off   = ldr_off[cur_ldr];
  assign sel_bytes = ldr_bytes[cur_ldr];

  vfa_addr_calc u_calc (
    .base_units (base_units),
    .sel_off    (sel_off),
    .sel_bytes  (sel_bytes),
    .vtx_idx    (vtx_idx),
    .vtx_num    (vtx_num),
    .idx_off    (idx_off),
    .idx_wide   (idx_wide),
    .is_idx     (req_is_idx),
    .addr       (req_addr),
    .len        (req_len)
  );

  assign req_kind   = req_is_idx;
  assign req_loader = req_is_idx ? 4'd0 : 4'(cur_ldr);

  AST_IDX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind |-> req_len == (idx_wide ? 8'd2 : 8'd1) && req_loader == 4'd0) // R5
    else $error("index request length wrong");

  AST_ATTR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_kind |-> req_len == ldr_bytes[req_loader]) // R3
    else $error("attribute length wrong");
endmodule

// File: tb/vtx_fetch_agen_tb_top.sv
`timescale 1ns/1ps
module vtx_fetch_agen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [7:0]  req_len;
  logic        req_kind;
  logic [3:0]  req_loader;
  logic        idx_rvalid = 1'b0;
  logic        idx_rready;
  logic [15:0] idx_rdata = '0;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;

  vtx_fetch_agen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .req_kind(req_kind), .req_loader(req_loader), .idx_rvalid(idx_rvalid),
    .idx_rready(idx_rready), .idx_rdata(idx_rdata), .busy(busy), .done(done)
  );

  initial forever #2.5 clk = ~clk;

  // Bench copy of the programmed configuration
  bit [28:0]  m_base;
  bit [31:0]  m_off   [12];
  bit [7:0]   m_bytes [12];
  bit [3:0]   m_cc    [12];
  bit [30:0]  m_ioff;
  bit         m_wide;
  bit [31:0]  m_cnt;
  bit [15:0]  m_itab  [16];

  // Expected request list
  bit [31:0] e_addr [256];
  bit [7:0]  e_len  [256];
  bit        e_kind [256];
  bit [3:0]  e_ldr  [256];
  int        n_exp;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_sim();
  end

  task automatic wr(input bit [9:0] a, input bit [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_cfg(input int cnt, input int act_pct, input bit wide);
    m_base = 29'($urandom);
    wr(10'h200, {3'($urandom), m_base});
    for (int l = 0; l < 12; l++) begin
      m_off[l]   = $urandom;
      m_bytes[l] = 8'($urandom_range(1, 64));
      m_cc[l]    = ($urandom_range(0, 99) < act_pct) ? 4'($urandom_range(1, 15)) : 4'd0;
      wr(10'(10'h203 + 3 * l), m_off[l]);
      wr(10'(10'h205 + 3 * l), {m_cc[l], 4'($urandom), m_bytes[l], 16'($urandom)});
    end
    m_ioff = 31'($urandom);
    m_wide = wide;
    wr(10'h227, {m_wide, m_ioff});
    m_cnt = 32'(cnt);
    wr(10'h228, m_cnt);
    for (int i = 0; i < 16; i++) m_itab[i] = 16'($urandom);
  endtask

  function automatic void build_exp(input bit indexed);
    bit [31:0] b8;
    bit [31:0] v;
    bit        any;
    b8 = {m_base, 3'b000};
    n_exp = 0;
    any = 1'b0;
    for (int l = 0; l < 12; l++) if (m_cc[l] != 0) any = 1'b1;
    if (m_cnt == 0 || !any) return;
    for (int i = 0; i < int'(m_cnt); i++) begin
      if (indexed) begin
        e_addr[n_exp] = b8 + {1'b0, m_ioff} + (m_wide ? 32'(2 * i) : 32'(i));
        e_len[n_exp]  = m_wide ? 8'd2 : 8'd1;
        e_kind[n_exp] = 1'b1;
        e_ldr[n_exp]  = 4'd0;
        n_exp++;
        v = m_wide ? 32'(m_itab[i]) : 32'(m_itab[i][7:0]);
      end else begin
        v = 32'(i);
      end
      for (int l = 0; l < 12; l++) begin
        if (m_cc[l] != 0) begin
          e_addr[n_exp] = b8 + m_off[l] + v * 32'(m_bytes[l]);
          e_len[n_exp]  = m_bytes[l];
          e_kind[n_exp] = 1'b0;
          e_ldr[n_exp]  = 4'(l);
          n_exp++;
        end
      end
    end
  endfunction

  // Runs one draw and compares the request stream with the expectation
  task automatic run_draw(input bit indexed, input int rdy_pct, input bit inject, input string tag);
    int  k = 0;
    int  cyc = 0;
    int  idx_acc = 0;
    int  dones = 0;
    bit  busy_seen = 1'b0;
    bit  stalled = 1'b0;
    bit [31:0] st_addr = '0;
    bit  rdy;
    build_exp(indexed);
    wr(indexed ? 10'h22F : 10'h22E, $urandom);
    forever begin
      if (busy) busy_seen = 1'b1;
      if (req_valid) begin
        if (stalled)
          check(req_addr == st_addr, "R6", "addr stable while stalled", req_addr, st_addr);
        check(busy, "R7", "busy with request", busy, 1);
        if (k >= n_exp) begin
          check(1'b0, tag, "extra request", k, n_exp);
        end else begin
          check(req_addr == e_addr[k], e_kind[k] ? "R5" : "R3", "addr", req_addr, e_addr[k]);
          check(req_len == e_len[k], e_kind[k] ? "R5" : "R3", "len", req_len, e_len[k]);
          check(req_kind == e_kind[k] && req_loader == e_ldr[k], "R4", "kind/loader",
                {req_kind, req_loader}, {e_kind[k], e_ldr[k]});
        end
        rdy = ($urandom_range(0, 99) < rdy_pct);
        req_ready = rdy;
        stalled = !rdy;
        st_addr = req_addr;
        if (rdy) begin
          if (k < n_exp && e_kind[k]) idx_acc++;
          k++;
        end
      end else begin
        req_ready = 1'($urandom);
        stalled = 1'b0;
      end
      idx_rvalid = ($urandom_range(0, 99) < 60);
      idx_rdata  = (idx_acc > 0) ? m_itab[idx_acc - 1] : 16'($urandom);
      if (inject && cyc == 3) begin
        cfg_we = 1'b1; cfg_addr = 10'h22F; cfg_wdata = $urandom;
      end else begin
        cfg_we = 1'b0;
      end
      if (done) begin
        dones++;
        check(!busy, "R7", "busy low at done", busy, 0);
        req_ready = 1'b0; idx_rvalid = 1'b0; cfg_we = 1'b0;
        break;
      end
      if (cyc > 6000) begin
        check(1'b0, tag, "draw timeout", cyc, 6000);
        req_ready = 1'b0; idx_rvalid = 1'b0; cfg_we = 1'b0;
        break;
      end
      @(negedge clk);
      cyc++;
    end
    check(k == n_exp, tag, "request count", k, n_exp);
    if (n_exp == 0) check(!busy_seen, "R9", "busy stayed low", busy_seen, 0);
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      check(!done && !busy && !req_valid, inject ? "R8" : "R7", "idle after draw",
            {done, busy, req_valid}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy && !done && !req_valid && !idx_rready, "R1", "reset outputs",
          {busy, done, req_valid, idx_rready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !req_valid, "R1", "idle without trigger",
          {busy, done, req_valid}, 0);

    // Directed: single vertex, every loader active, full ready
    program_cfg(1, 100, 1'b0);
    run_draw(1'b0, 100, 1'b0, "R2");

    // Directed: count zero, and all loaders inactive
    program_cfg(0, 100, 1'b0);
    run_draw(1'b0, 100, 1'b0, "R9");
    program_cfg(3, 0, 1'b1);
    run_draw(1'b1, 100, 1'b0, "R9");

    // Directed: ignored words written before a plain draw
    program_cfg(3, 50, 1'b0);
    wr(10'h201, $urandom);
    wr(10'h202, $urandom);
    for (int l = 0; l < 12; l++) wr(10'(10'h204 + 3 * l), $urandom);
    wr(10'h22A, $urandom);
    wr(10'h1FF, $urandom);
    run_draw(1'b0, 70, 1'b0, "R10");

    // Directed: narrow and wide indexed draws with injected trigger
    program_cfg(6, 60, 1'b0);
    run_draw(1'b1, 40, 1'b1, "R8");
    program_cfg(6, 60, 1'b1);
    run_draw(1'b1, 40, 1'b1, "R8");

    // Random mix
    for (int n = 0; n < 30; n++) begin
      bit ind;
      ind = 1'($urandom);
      program_cfg($urandom_range(1, 8), 50, 1'($urandom));
      run_draw(ind, $urandom_range(20, 100), (n % 4) == 0, ind ? "R5" : "R2");
    end

    finish_sim();
  end
endmodule